// File: doc/BRIEF.md
# Spatial Noise Dither for Pixel Depth Reduction

This block takes a stream of pixels with three 12-bit components (RGB or YCbCr) and cuts each component down to 6, 8 or 10 significant bits. Before the low bits are dropped, it adds a small pseudo-random value to the component. The rounding error therefore becomes fine spatial noise and not visible banding. The noise comes from 28-bit linear feedback shift registers that are loaded from software seeds.

There are two ways to source the noise. All three channels can share one generator, or each channel can use its own generator with a different feedback tap. The generators can be reloaded at every frame start, with a small frame-counter value folded into the seed, or they can run freely from the moment the block is enabled. An optional high-pass stage replaces each raw noise sample with the offset, halved difference from the previous sample. When the block is disabled, pixels pass through unchanged. Configuration inputs may change only while the enable is low.

The output keeps the 12-bit component format. The retained bits stay in the upper positions and the discarded low bits are cleared, so a neighbouring stage can take the top 6, 8 or 10 bits directly.

Top module: `noise_dither`

## Requirements
- R1: Every pixel appears at the output exactly two clock cycles after it is presented. The valid, start-of-frame and end-of-line strobes are delayed by the same amount. Start-of-frame and end-of-line are only ever output together with valid. After reset the outputs are zero.
- R2: While the enable is low, each valid pixel leaves unchanged.
- R3: Depth code 0 keeps 6 bits per component, code 1 keeps 8 and code 2 keeps 10. Code 3 behaves as code 2. When the enable is high, the discarded low bits (6, 4 or 2 of them) of each output component are zero.
- R4: When enabled, the noise for a component is as wide as the discarded field. The noise is added to the 12-bit input, the sum saturates at 4095, and the discarded bits are then cleared. An output component is never below the input with its discarded bits cleared.
- R5: A generator state s steps to {s[26:0], s[27] ^ s[k-1]} for a polynomial x^28 + x^k + 1. It steps once per valid pixel while enabled and holds on idle cycles. The raw noise is the low bits of the state used for that pixel.
- R6: With the per-channel select low, all three components take the noise of the R generator (k = 3).
- R7: With the per-channel select high, R, G and B (bits 11:0, 23:12 and 35:24 of the pixel) use generators with k = 3, 9 and 13, each loaded from its own seed.
- R8: On the first enabled cycle after a disabled cycle, every generator starts from its seed, the stored previous noise is zero and the frame counter is zero.
- R9: With frame-random on, a valid start-of-frame pixel reloads every generator with its seed XOR the bit-swapped frame count in bits 3:0, and uses that reloaded state. With frame-random off, start-of-frame does not disturb the generators.
- R10: Each valid start-of-frame pixel advances the frame counter after use. With frame-random on, the counter wraps from 15 to 0 and its four bits are reversed for depth codes 0 and 1. For codes 2 and 3 it wraps from 3 to 0 and its two low bits are swapped. With frame-random off, the wrap value is 0 and no swap is applied.
- R11: With the high-pass option on, the noise is ((raw - previous raw) + 2^D) >> 1, where D is the discarded width and previous raw is the prior pixel's raw noise on that generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Dither enable; low means bypass |
| cfg_depth | input | 2 | Output depth code (0: 6, 1: 8, 2/3: 10 bits) |
| cfg_rgb_rand | input | 1 | 1: separate generator per channel; 0: shared R generator |
| cfg_frame_rand | input | 1 | Reload generators at every frame start |
| cfg_hp_en | input | 1 | High-pass filter on the noise |
| cfg_seed_r | input | 28 | Seed for the R generator |
| cfg_seed_g | input | 28 | Seed for the G generator |
| cfg_seed_b | input | 28 | Seed for the B generator |
| in_vld | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input start of frame |
| in_eol | input | 1 | Input end of line |
| in_pix | input | 36 | Input pixel, R in 11:0, G in 23:12, B in 35:24 |
| out_vld | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output start of frame |
| out_eol | output | 1 | Output end of line |
| out_pix | output | 36 | Output pixel, same layout, discarded bits cleared |

## Verification
The stimulus is a mix of mid-range ramps, which expose the exact noise added at each depth, and components pinned near 4095, which can only pass if the sum saturates. Frames broken up by idle cycles show whether the generators hold between pixels. Runs with equal seeds but a different per-channel select tell shared noise apart from per-channel noise. Long runs of short frames with frame-random on walk the counter through its wrap in both depth groups, and the high-pass runs compare filtered noise against raw noise from the same seeds.

// File: rtl/dith_pkg.sv
package dith_pkg;

    localparam int CW  = 12;   // component width at the input
    localparam int LW  = 28;   // generator state width
    localparam int NCH = 3;    // components per pixel
    localparam int NW  = 6;    // widest discarded field
    localparam int PW  = 4;    // frame counter / perturbation width

    typedef logic [1:0] depth_t;

    // number of low bits removed for a depth code
    function automatic logic [2:0] drop_bits(input depth_t d);
        case (d)
            2'd0:    return 3'd6;
            2'd1:    return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    // frame counter wrap value
    function automatic logic [PW-1:0] wrap_val(input logic frand, input depth_t d);
        if (!frand)       return '0;
        else if (d < 2'd2) return 4'd15;
        else               return 4'd3;
    endfunction

    // bit-swap setting: 0 none, 1 two-bit swap, 2 four-bit reverse
    function automatic logic [1:0] swap_sel(input logic frand, input depth_t d);
        if (!frand)       return 2'd0;
        else if (d < 2'd2) return 2'd2;
        else               return 2'd1;
    endfunction

    function automatic logic [PW-1:0] swap_cnt(input logic [PW-1:0] c, input logic [1:0] sel);
        case (sel)
            2'd2:    return {c[0], c[1], c[2], c[3]};
            2'd1:    return {c[3:2], c[0], c[1]};
            default: return c;
        endcase
    endfunction

endpackage

// File: rtl/dith_fctr.sv
module dith_fctr
    import dith_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          vld,
    input  logic          sof,
    input  logic          frand,
    input  depth_t        depth,
    output logic [PW-1:0] pert
);

    typedef struct packed {
        logic          en;
        logic [PW-1:0] cnt;
    } fc_t;

    fc_t q, d;
    logic [PW-1:0] cur_cnt;
    logic [PW-1:0] lim;

    always_comb begin
        cur_cnt = q.en ? q.cnt : '0;
        lim     = wrap_val(frand, depth);
        pert    = swap_cnt(cur_cnt, swap_sel(frand, depth));
        d.en    = en;
        d.cnt   = cur_cnt;
        if (en && vld && sof) begin
            d.cnt = (cur_cnt >= lim) ? '0 : cur_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/dith_lfsr.sv
module dith_lfsr #(
    parameter int LW  = 28,
    parameter int TAP = 3,
    parameter int NW  = 6,
    parameter int PW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          vld,
    input  logic          reload,
    input  logic [LW-1:0] seed,
    input  logic [PW-1:0] pert,
    input  logic [2:0]    drop,
    input  logic          hp_en,
    output logic [NW-1:0] noise
);

    typedef struct packed {
        logic          en;
        logic [LW-1:0] lfsr;
        logic [NW-1:0] prev;
    } gen_t;

    gen_t q, d;
    logic [LW-1:0] base, cur;
    logic [NW-1:0] prv, mask, raw, hp;
    logic [NW+1:0] diff;

    always_comb begin
        // a disabled previous cycle means the generator restarts at its seed
        base  = q.en ? q.lfsr : seed;
        prv   = q.en ? q.prev : '0;
        cur   = reload ? (seed ^ {{(LW-PW){1'b0}}, pert}) : base;
        mask  = ~({NW{1'b1}} << drop);
        raw   = cur[NW-1:0] & mask;
        diff  = {2'b00, raw} + ({{(NW+1){1'b0}}, 1'b1} << drop) - {2'b00, prv};
        hp    = NW'(diff >> 1) & mask;
        noise = hp_en ? hp : raw;

        d.en   = en;
        d.lfsr = base;
        d.prev = prv;
        if (en && vld) begin
            d.lfsr = {cur[LW-2:0], cur[LW-1] ^ cur[TAP-1]};
            d.prev = raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/dith_quant.sv
module dith_quant #(
    parameter int CW = 12,
    parameter int NW = 6
) (
    input  logic [CW-1:0] pix,
    input  logic [NW-1:0] noise,
    input  logic [2:0]    drop,
    input  logic          en,
    output logic [CW-1:0] res
);

    logic [CW:0]   sum;
    logic [CW-1:0] sat, keep;

    always_comb begin
        sum  = {1'b0, pix} + (CW+1)'(noise);
        sat  = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
        keep = {CW{1'b1}} << drop;
        res  = en ? (sat & keep) : pix;
    end

endmodule

// File: rtl/noise_dither.sv
module noise_dither
    import dith_pkg::*;
#(
    parameter int CW    = dith_pkg::CW,
    parameter int LW    = dith_pkg::LW,
    parameter int NCH   = dith_pkg::NCH,
    parameter int NW    = dith_pkg::NW,
    parameter int TAP_R = 3,
    parameter int TAP_G = 9,
    parameter int TAP_B = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [1:0]         cfg_depth,
    input  logic               cfg_rgb_rand,
    input  logic               cfg_frame_rand,
    input  logic               cfg_hp_en,
    input  logic [LW-1:0]      cfg_seed_r,
    input  logic [LW-1:0]      cfg_seed_g,
    input  logic [LW-1:0]      cfg_seed_b,
    input  logic               in_vld,
    input  logic               in_sof,
    input  logic               in_eol,
    input  logic [NCH*CW-1:0]  in_pix,
    output logic               out_vld,
    output logic               out_sof,
    output logic               out_eol,
    output logic [NCH*CW-1:0]  out_pix
);

    localparam int PXW = NCH * CW;
    localparam int NZW = NCH * NW;

    typedef struct packed {
        logic           vld;
        logic           sof;
        logic           eol;
        logic           en;
        logic [2:0]     drop;
        logic [PXW-1:0] pix;
        logic [NZW-1:0] nz;
    } s1_t;

    typedef struct packed {
        logic           vld;
        logic           sof;
        logic           eol;
        logic [PXW-1:0] pix;
    } s2_t;

    s1_t s1_q, s1_d;
    s2_t s2_q, s2_d;

    logic [2:0]     drop0;
    logic           reload;
    logic [PW-1:0]  pert;
    logic [LW-1:0]  seeds [NCH];
    logic [NW-1:0]  gnz   [NCH];
    logic [PXW-1:0] qpix;

    assign drop0  = drop_bits(cfg_depth);
    assign reload = in_vld & in_sof & cfg_frame_rand;

    dith_fctr u_fctr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_en),
        .vld   (in_vld),
        .sof   (in_sof),
        .frand (cfg_frame_rand),
        .depth (cfg_depth),
        .pert  (pert)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam int TAP = (c == 0) ? TAP_R : ((c == 1) ? TAP_G : TAP_B);

            assign seeds[c] = (c == 0) ? cfg_seed_r : ((c == 1) ? cfg_seed_g : cfg_seed_b);

            dith_lfsr #(.LW(LW), .TAP(TAP), .NW(NW), .PW(PW)) u_gen (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (cfg_en),
                .vld    (in_vld),
                .reload (reload),
                .seed   (seeds[c]),
                .pert   (pert),
                .drop   (drop0),
                .hp_en  (cfg_hp_en),
                .noise  (gnz[c])
            );

            dith_quant #(.CW(CW), .NW(NW)) u_q (
                .pix   (s1_q.pix[c*CW +: CW]),
                .noise (s1_q.nz[c*NW +: NW]),
                .drop  (s1_q.drop),
                .en    (s1_q.en),
                .res   (qpix[c*CW +: CW])
            );
        end
    endgenerate

    always_comb begin
        s1_d.vld  = in_vld;
        s1_d.sof  = in_vld & in_sof;
        s1_d.eol  = in_vld & in_eol;
        s1_d.en   = cfg_en;
        s1_d.drop = drop0;
        s1_d.pix  = in_pix;
        s1_d.nz   = '0;
        for (int c = 0; c < NCH; c++) begin
            s1_d.nz[c*NW +: NW] = cfg_rgb_rand ? gnz[c] : gnz[0];
        end

        s2_d.vld = s1_q.vld;
        s2_d.sof = s1_q.sof;
        s2_d.eol = s1_q.eol;
        s2_d.pix = qpix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_vld = s2_q.vld;
    assign out_sof = s2_q.sof;
    assign out_eol = s2_q.eol;
    assign out_pix = s2_q.pix;

endmodule

// File: rtl/dith_chk.sv
module dith_chk
    import dith_pkg::*;
#(
    parameter int CW  = dith_pkg::CW,
    parameter int NCH = dith_pkg::NCH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic [1:0]        cfg_depth,
    input logic              in_vld,
    input logic [NCH*CW-1:0] in_pix,
    input logic              out_vld,
    input logic              out_sof,
    input logic              out_eol,
    input logic [NCH*CW-1:0] out_pix
);

    logic [1:0]        age;
    logic              vld_1, vld_2, en_1, en_2;
    logic [1:0]        dep_1, dep_2;
    logic [NCH*CW-1:0] pix_1, pix_2;
    logic [CW-1:0]     keep2;
    logic              warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age   <= '0;
            vld_1 <= 1'b0; vld_2 <= 1'b0;
            en_1  <= 1'b0; en_2  <= 1'b0;
            dep_1 <= '0;   dep_2 <= '0;
            pix_1 <= '0;   pix_2 <= '0;
        end else begin
            if (age != 2'd3) age <= age + 2'd1;
            vld_1 <= in_vld;    vld_2 <= vld_1;
            en_1  <= cfg_en;    en_2  <= en_1;
            dep_1 <= cfg_depth; dep_2 <= dep_1;
            pix_1 <= in_pix;    pix_2 <= pix_1;
        end
    end

    assign warm  = (age >= 2'd2);
    assign keep2 = {CW{1'b1}} << drop_bits(dep_2);

    // R1
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_vld == vld_2));

    // R1
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eol) |-> out_vld);

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_vld && !en_2) |-> (out_pix == pix_2));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_c
            // R3
            low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm && out_vld && en_2) |-> ((out_pix[c*CW +: CW] & ~keep2) == '0));

            // R4
            no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm && out_vld && en_2) |-> (out_pix[c*CW +: CW] >= (pix_2[c*CW +: CW] & keep2)));
        end
    endgenerate

endmodule

bind noise_dither dith_chk #(.CW(CW), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_depth (cfg_depth),
    .in_vld    (in_vld),
    .in_pix    (in_pix),
    .out_vld   (out_vld),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .out_pix   (out_pix)
);

// File: tb/noise_dither_test.sv
module noise_dither_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_depth = '0;
    logic        cfg_rgb_rand = 1'b0;
    logic        cfg_frame_rand = 1'b0;
    logic        cfg_hp_en = 1'b0;
    logic [27:0] cfg_seed_r = '0, cfg_seed_g = '0, cfg_seed_b = '0;
    logic        in_vld = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [35:0] in_pix = '0;
    logic        out_vld, out_sof, out_eol;
    logic [35:0] out_pix;

    noise_dither uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_depth(cfg_depth),
        .cfg_rgb_rand(cfg_rgb_rand), .cfg_frame_rand(cfg_frame_rand), .cfg_hp_en(cfg_hp_en),
        .cfg_seed_r(cfg_seed_r), .cfg_seed_g(cfg_seed_g), .cfg_seed_b(cfg_seed_b),
        .in_vld(in_vld), .in_sof(in_sof), .in_eol(in_eol), .in_pix(in_pix),
        .out_vld(out_vld), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
    );

    always #2 clk = ~clk;   // 250 MHz

    int    checks = 0, errors = 0, cyc = 0;
    bit    done = 1'b0, live = 1'b0;
    string tag = "R1";

    // bench-side configuration, applied at the next driven cycle
    bit       b_en = 0, b_rgb = 0, b_fr = 0, b_hp = 0;
    int       b_dep = 0;
    bit [27:0] b_seed [3];

    // behavioural model state
    bit [27:0] st [3];
    int        prv [3];
    int        fcnt = 0;
    bit        en_prev = 0;
    int        taps [3] = '{3, 9, 13};

    typedef struct { int cyc; logic [35:0] pix; bit sof; bit eol; } exp_t;
    exp_t q [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rev_bits(int v, int w);
        int r = 0;
        for (int i = 0; i < w; i++) if (v & (1 << i)) r |= 1 << (w - 1 - i);
        return r;
    endfunction

    function automatic logic [35:0] mkpix(int k, bit hi);
        logic [35:0] p;
        for (int c = 0; c < 3; c++) begin
            if (hi) p[c*12 +: 12] = 12'(4095 - ((k + c) % 7));
            else    p[c*12 +: 12] = 12'((k * 397 + c * 1117 + 59) % 4096);
        end
        return p;
    endfunction

    task automatic cycle(bit v, bit s, bit e, logic [35:0] p);
        exp_t  x;
        int    dsc, lim, sw, raw, nz;
        int    nzc [3];
        @(negedge clk);
        cfg_en = b_en; cfg_depth = 2'(b_dep); cfg_rgb_rand = b_rgb;
        cfg_frame_rand = b_fr; cfg_hp_en = b_hp;
        cfg_seed_r = b_seed[0]; cfg_seed_g = b_seed[1]; cfg_seed_b = b_seed[2];
        in_vld = v; in_sof = s; in_eol = e; in_pix = p;
        x.cyc = cyc; x.sof = s; x.eol = e; x.pix = p;
        dsc = (b_dep == 0) ? 6 : ((b_dep == 1) ? 4 : 2);
        if (b_en) begin
            if (!en_prev) begin
                for (int c = 0; c < 3; c++) begin st[c] = b_seed[c]; prv[c] = 0; end
                fcnt = 0;
            end
            if (v) begin
                if (s && b_fr) begin
                    sw = (b_dep < 2) ? rev_bits(fcnt, 4) : rev_bits(fcnt, 2);
                    for (int c = 0; c < 3; c++) st[c] = b_seed[c] ^ 28'(sw);
                end
                for (int c = 0; c < 3; c++) begin
                    raw = int'(st[c]) % (1 << dsc);
                    nz  = b_hp ? ((raw - prv[c] + (1 << dsc)) / 2) : raw;
                    prv[c] = raw;
                    nzc[c] = nz;
                    st[c] = {st[c][26:0], st[c][27] ^ st[c][taps[c] - 1]};
                end
                if (s) begin
                    lim  = !b_fr ? 0 : ((b_dep < 2) ? 15 : 3);
                    fcnt = (fcnt >= lim) ? 0 : fcnt + 1;
                end
                for (int c = 0; c < 3; c++) begin
                    int sum;
                    sum = int'(p[c*12 +: 12]) + (b_rgb ? nzc[c] : nzc[0]);
                    if (sum > 4095) sum = 4095;
                    sum = sum - (sum % (1 << dsc));
                    x.pix[c*12 +: 12] = 12'(sum);
                end
            end
        end
        en_prev = b_en;
        if (v) q.push_back(x);
    endtask

    task automatic frame(int n, bit gaps, bit hi, int base);
        for (int i = 0; i < n; i++) begin
            cycle(1, i == 0, i == n - 1, mkpix(base + i, hi));
            if (gaps && (i % 3 == 1)) cycle(0, 0, 0, '0);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, '0);
    endtask

    // output comparison, sampled mid-cycle
    always @(negedge clk) begin
        if (live) begin
            checks++;
            if (q.size() > 0 && q[0].cyc + 2 == cyc) begin
                if (out_vld !== 1'b1 || out_pix !== q[0].pix ||
                    out_sof !== q[0].sof || out_eol !== q[0].eol) begin
                    errors++;
                    $display("FAIL %s: vld=%b sof=%b eol=%b pix=%h expected vld=1 sof=%b eol=%b pix=%h",
                             tag, out_vld, out_sof, out_eol, out_pix, q[0].sof, q[0].eol, q[0].pix);
                end
                void'(q.pop_front());
            end else if (out_vld !== 1'b0) begin
                errors++;
                $display("FAIL %s (R1 timing): out_vld=%b expected 0", tag, out_vld);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        b_seed[0] = 28'h5A51234; b_seed[1] = 28'hC3F0A01; b_seed[2] = 28'h137BEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (out_vld !== 1'b0 || out_sof !== 1'b0 || out_eol !== 1'b0 || out_pix !== '0) begin
            errors++;
            $display("FAIL R1: reset outputs vld=%b pix=%h expected 0 and 0", out_vld, out_pix);
        end
        rst_n = 1'b1;
        idle(2);
        live = 1'b1;

        tag = "R2";  b_en = 0; frame(8, 1, 0, 0);
        tag = "R6";  b_en = 1; b_dep = 1; b_rgb = 0; frame(12, 1, 0, 20);
        tag = "R5";  frame(10, 1, 0, 40); idle(3); frame(6, 0, 0, 60);
        tag = "R7";  b_en = 0; idle(1); b_en = 1; b_dep = 0; b_rgb = 1; frame(12, 0, 0, 70);
        tag = "R3";  b_en = 0; idle(1); b_en = 1; b_dep = 2; frame(10, 1, 0, 90);
        b_en = 0; idle(1); b_en = 1; b_dep = 3; frame(10, 0, 0, 110);
        tag = "R4";  b_en = 0; idle(1); b_en = 1; b_dep = 0; frame(14, 0, 1, 0);
        b_en = 0; idle(1); b_en = 1; b_dep = 1; b_rgb = 0; frame(10, 1, 1, 5);
        tag = "R9";  b_en = 0; idle(1); b_en = 1; b_dep = 1; b_rgb = 1; b_fr = 1;
        for (int f = 0; f < 3; f++) frame(3, 0, 0, 130 + f);
        tag = "R10";
        for (int f = 0; f < 18; f++) frame(3, f % 2, 0, 140 + f);
        b_en = 0; idle(1); b_en = 1; b_dep = 2;
        for (int f = 0; f < 7; f++) frame(3, 0, 0, 170 + f);
        tag = "R9";  b_en = 0; idle(1); b_en = 1; b_fr = 0; b_dep = 1;
        for (int f = 0; f < 3; f++) frame(4, 0, 0, 180 + f);
        tag = "R11"; b_en = 0; idle(1); b_en = 1; b_hp = 1; b_dep = 0; frame(16, 1, 0, 200);
        b_en = 0; idle(1); b_en = 1; b_dep = 1; b_rgb = 0; frame(12, 0, 0, 220);
        tag = "R8";  b_en = 0; b_hp = 0; idle(1);
        b_seed[0] = 28'h0F0F0F3; b_seed[1] = 28'h7654321; b_seed[2] = 28'h8000011;
        idle(2); b_en = 1; b_rgb = 1; b_dep = 0; frame(8, 0, 0, 240);
        b_en = 0; idle(2); b_en = 1; frame(8, 0, 0, 240);
        idle(4);
        live = 1'b0;
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d pixels never left, expected 0", q.size());
        end
        finish_run();
    end

endmodule